// File: doc/BRIEF.md
# Clock Multiplier Configuration Governor

This block keeps a 16-bit clock setup word that is written through a single-cycle write strobe. It splits the word into a base multiplier code, an allowance code for extra multiplier headroom, and a code for the crystal frequency. From these fields it derives the crystal frequency and the core clock frequency in kHz, and the highest sample rate the crystal supports. All of these are presented continuously on output ports.

A small governor sits beside the arithmetic. While the automatic mode input is high, a workload demand pair asks for more or fewer core cycles. The governor then moves the active multiplier up or down by half a unit at a time. It stays between the base multiplier and the base plus the allowance. A programmable settle interval limits how often it may move. The base setting is at least 2.0× whenever the base code is non-zero, so automatic changes never fall back to the 1.0× crystal clock in the middle of a stream. The PLL itself and the clock switching are left to surrounding logic.

Top module: `clkcfg_governor`

## Requirements
- R1: A write stores `wr_data` at the clock edge where `wr_en` is high, and `cfg_q` shows it from then on. After reset `cfg_q` is 0x0000.
- R2: The base multiplier code sits in bits 15:13. Code 0 yields `base_half` = 2 (1.0×), and code n from 1 to 7 yields n+3 (2.0× up to 5.0× in half-unit counts).
- R3: The allowance code sits in bits 12:11. `ceil_half` equals `base_half` plus 0, 2, 3 or 4 for codes 0, 1, 2 and 3.
- R4: The crystal code sits in bits 10:0. `xtal_khz` = 8000 + 4 × code, except that code 0 gives 12288.
- R5: `max_fs_hz` = floor(`xtal_khz` × 1000 / 256).
- R6: `core_khz` = `xtal_khz` × `act_half` / 2, and `act_half` always lies between `base_half` and `ceil_half` inclusive.
- R7: With automatic mode on and no write, `need_up` alone raises `act_half` by exactly 1 at a permitted edge if it is below `ceil_half`. `need_down` alone lowers it by exactly 1 if it is above `base_half`. It never moves by more than 1 per edge.
- R8: At the edge after a write, or after any edge with `auto_en` low, `act_half` equals the base multiplier of the stored word.
- R9: When `need_up` and `need_down` are both high, `act_half` does not change.
- R10: A settle counter is cleared by a write, by auto mode being off, or by a step, and it counts every other edge. A step is permitted only once the counter has reached `settle_cycles`. With demand held steadily, steps therefore land every `settle_cycles`+1 edges, counted from the write or from the previous step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the setup word |
| wr_data | input | 16 | Setup word to store |
| auto_en | input | 1 | Enables automatic multiplier changes |
| need_up | input | 1 | Workload asks for more cycles |
| need_down | input | 1 | Workload asks for fewer cycles |
| settle_cycles | input | SETTLE_W (8) | Minimum settle count between steps |
| cfg_q | output | 16 | Stored setup word |
| base_half | output | 4 | Base multiplier in half units |
| ceil_half | output | 4 | Ceiling multiplier in half units |
| act_half | output | 4 | Active multiplier in half units |
| xtal_khz | output | 14 | Crystal frequency in kHz |
| core_khz | output | 17 | Core clock frequency in kHz |
| max_fs_hz | output | 16 | Highest supported sample rate in Hz |

## Verification
A corrupted stored word or a decode slip shows up at once on `base_half`, `ceil_half`, `xtal_khz` and `max_fs_hz`, on the same cycle as the bad value. A wrong active multiplier shows up on `act_half` and `core_khz` at the next edge. A governor that runs past its bounds, skips a half-step or ignores a tie is visible within one demand cycle. A broken settle counter shifts the step edges and is seen within `settle_cycles`+1 edges of a write.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int CFG_W     = 16;
  localparam int MCODE_W   = 3;
  localparam int ACODE_W   = 2;
  localparam int FCODE_W   = 11;
  localparam int HALF_W    = 4;
  localparam int XK_W      = 14;
  localparam int XH_W      = 24;
  localparam int CORE_W    = XK_W + HALF_W - 1;
  localparam int FS_W      = XH_W - 8;
  localparam int XK_DEFAULT = 12288;
  localparam int XK_OFFSET  = 8000;
  localparam int XK_SHIFT   = 2;
  localparam int HZ_PER_KHZ = 1000;

  typedef struct packed {
    logic [MCODE_W-1:0] mcode;
    logic [ACODE_W-1:0] acode;
    logic [FCODE_W-1:0] fcode;
  } clk_setup_t;

  function automatic logic [HALF_W-1:0] mcode_to_half(input logic [MCODE_W-1:0] code);
    if (code == '0) return HALF_W'(2);
    else            return HALF_W'(code) + HALF_W'(3);
  endfunction

  function automatic logic [HALF_W-1:0] acode_to_half(input logic [ACODE_W-1:0] code);
    logic [HALF_W-1:0] r;
    case (code)
      2'd0:    r = HALF_W'(0);
      2'd1:    r = HALF_W'(2);
      2'd2:    r = HALF_W'(3);
      default: r = HALF_W'(4);
    endcase
    return r;
  endfunction

  localparam logic [HALF_W-1:0] RESET_HALF = HALF_W'(2);
endpackage

// File: rtl/clkcfg_reg.sv
module clkcfg_reg
  import clkcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output clk_setup_t       setup_q
);
  clk_setup_t setup_d;

  always_comb begin
    setup_d = setup_q;
    if (wr_en) setup_d = clk_setup_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) setup_q <= '0;
    else        setup_q <= setup_d;
  end
endmodule

// File: rtl/clkcfg_decode.sv
module clkcfg_decode
  import clkcfg_pkg::*;
(
  input  clk_setup_t        setup,
  input  logic [HALF_W-1:0] act_half,
  output logic [HALF_W-1:0] base_half,
  output logic [HALF_W-1:0] ceil_half,
  output logic [XK_W-1:0]   xtal_khz,
  output logic [CORE_W-1:0] core_khz,
  output logic [FS_W-1:0]   max_fs_hz
);
  localparam int PROD_W = XK_W + HALF_W;

  logic [XH_W-1:0]   xtal_hz;
  logic [PROD_W-1:0] prod;

  always_comb begin
    base_half = mcode_to_half(setup.mcode);
    ceil_half = base_half + acode_to_half(setup.acode);
  end

  always_comb begin
    if (setup.fcode == '0)
      xtal_khz = XK_W'(XK_DEFAULT);
    else
      xtal_khz = XK_W'(XK_OFFSET) + (XK_W'(setup.fcode) << XK_SHIFT);
  end

  always_comb begin
    xtal_hz   = XH_W'(xtal_khz) * XH_W'(HZ_PER_KHZ);
    max_fs_hz = xtal_hz[XH_W-1:8];
  end

  always_comb begin
    prod     = PROD_W'(xtal_khz) * PROD_W'(act_half);
    core_khz = prod[PROD_W-1:1];
  end
endmodule

// File: rtl/clkcfg_gov.sv
module clkcfg_gov
  import clkcfg_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [HALF_W-1:0]   restart_half,
  input  logic                need_up,
  input  logic                need_down,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [HALF_W-1:0]   base_half,
  input  logic [HALF_W-1:0]   ceil_half,
  output logic [HALF_W-1:0]   act_half
);
  localparam logic [SETTLE_W-1:0] TMR_MAX = '1;

  logic [SETTLE_W-1:0] tmr_q, tmr_d;
  logic [HALF_W-1:0]   act_d;
  logic                ready, go_up, go_down, step;

  always_comb begin
    ready   = (tmr_q >= settle_cycles);
    go_up   = need_up && !need_down && (act_half < ceil_half);
    go_down = need_down && !need_up && (act_half > base_half);
    step    = ready && (go_up || go_down);
  end

  always_comb begin
    act_d = act_half;
    tmr_d = tmr_q;
    if (restart) begin
      act_d = restart_half;
      tmr_d = '0;
    end else if (step) begin
      act_d = go_up ? act_half + HALF_W'(1) : act_half - HALF_W'(1);
      tmr_d = '0;
    end else if (tmr_q != TMR_MAX) begin
      tmr_d = tmr_q + SETTLE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_half <= RESET_HALF;
      tmr_q    <= '0;
    end else begin
      act_half <= act_d;
      tmr_q    <= tmr_d;
    end
  end
endmodule

// File: rtl/clkcfg_governor.sv
module clkcfg_governor
  import clkcfg_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [15:0]         wr_data,
  input  logic                auto_en,
  input  logic                need_up,
  input  logic                need_down,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [15:0]         cfg_q,
  output logic [3:0]          base_half,
  output logic [3:0]          ceil_half,
  output logic [3:0]          act_half,
  output logic [13:0]         xtal_khz,
  output logic [16:0]         core_khz,
  output logic [15:0]         max_fs_hz
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  clk_setup_t        setup_q;
  clk_setup_t        wr_setup;
  logic              restart;
  logic [HALF_W-1:0] restart_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  clkcfg_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .setup_q (setup_q)
  );

  always_comb begin
    wr_setup     = clk_setup_t'(wr_data);
    restart      = wr_en || !auto_en;
    restart_half = wr_en ? mcode_to_half(wr_setup.mcode) : base_half;
  end

  clkcfg_gov #(.SETTLE_W(SETTLE_W)) u_gov (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .restart       (restart),
    .restart_half  (restart_half),
    .need_up       (need_up),
    .need_down     (need_down),
    .settle_cycles (settle_cycles),
    .base_half     (base_half),
    .ceil_half     (ceil_half),
    .act_half      (act_half)
  );

  clkcfg_decode u_dec (
    .setup     (setup_q),
    .act_half  (act_half),
    .base_half (base_half),
    .ceil_half (ceil_half),
    .xtal_khz  (xtal_khz),
    .core_khz  (core_khz),
    .max_fs_hz (max_fs_hz)
  );

  assign cfg_q = setup_q;
endmodule

// File: rtl/clkcfg_governor_chk.sv
module clkcfg_governor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        auto_en,
  input logic        need_up,
  input logic        need_down,
  input logic [15:0] cfg_q,
  input logic [3:0]  base_half,
  input logic [3:0]  ceil_half,
  input logic [3:0]  act_half
);
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data)));

  p_act_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_half >= base_half) && (act_half <= ceil_half));

  p_single_half_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !wr_en) |=> ((act_half == $past(act_half)) ||
                             (act_half == $past(act_half) + 4'd1) ||
                             (act_half + 4'd1 == $past(act_half))));

  p_back_to_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || !auto_en) |=> (act_half == base_half));

  p_tie_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !wr_en && need_up && need_down) |=> $stable(act_half));
endmodule

bind clkcfg_governor clkcfg_governor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .auto_en   (auto_en),
  .need_up   (need_up),
  .need_down (need_down),
  .cfg_q     (cfg_q),
  .base_half (base_half),
  .ceil_half (ceil_half),
  .act_half  (act_half)
);

// File: tb/sim_clkcfg_governor.sv
module sim_clkcfg_governor;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        auto_en;
  logic        need_up;
  logic        need_down;
  logic [7:0]  settle_cycles;
  logic [15:0] cfg_q;
  logic [3:0]  base_half, ceil_half, act_half;
  logic [13:0] xtal_khz;
  logic [16:0] core_khz;
  logic [15:0] max_fs_hz;

  int n_cmp = 0;
  int n_bad = 0;

  clkcfg_governor u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .auto_en(auto_en), .need_up(need_up), .need_down(need_down),
    .settle_cycles(settle_cycles), .cfg_q(cfg_q), .base_half(base_half),
    .ceil_half(ceil_half), .act_half(act_half), .xtal_khz(xtal_khz),
    .core_khz(core_khz), .max_fs_hz(max_fs_hz)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int exp_base(input int m);
    return (m == 0) ? 2 : m + 3;
  endfunction

  function automatic int exp_allow(input int a);
    case (a)
      0: return 0;
      1: return 2;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_xk(input int f);
    return (f == 0) ? 12288 : 8000 + 4 * f;
  endfunction

  task automatic write_word(input int w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 16'(w);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic check_static(input int m, input int a, input int f);
    int xk;
    xk = exp_xk(f);
    check("R1 cfg_q", int'(cfg_q), (m << 13) | (a << 11) | f);
    check("R2 base_half", int'(base_half), exp_base(m));
    check("R3 ceil_half", int'(ceil_half), exp_base(m) + exp_allow(a));
    check("R4 xtal_khz", int'(xtal_khz), xk);
    check("R5 max_fs_hz", int'(max_fs_hz), (xk * 1000) / 256);
    check("R6 core_khz", int'(core_khz), (xk * int'(act_half)) / 2);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int b, c, cur, xk, s;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; auto_en = 1'b0;
    need_up = 1'b0; need_down = 1'b0; settle_cycles = '0;
    repeat (3) @(negedge clk);
    // R1/R4/R5 reset state
    check("R1 reset cfg_q", int'(cfg_q), 0);
    check("R6 reset act_half", int'(act_half), 2);
    check("R4 reset xtal_khz", int'(xtal_khz), 12288);
    check("R5 reset max_fs_hz", int'(max_fs_hz), 48000);
    check("R6 reset core_khz", int'(core_khz), 12288);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Full crystal code sweep with one multiplier setting (R4, R5)
    for (int f = 0; f < 2048; f++) begin
      write_word((4 << 13) | (3 << 11) | f);
      check_static(4, 3, f);
    end

    // All multiplier and allowance codes with assorted crystal codes (R2, R3)
    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 4; a++) begin
        write_word((m << 13) | (a << 11) | ((m * 4 + a) * 61));
        check_static(m, a, (m * 4 + a) * 61);
      end

    // Governor climb and descent for every base and allowance (R6, R7, R8)
    settle_cycles = 8'd0;
    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 4; a++) begin
        b = exp_base(m);
        c = b + exp_allow(a);
        auto_en = 1'b1; need_up = 1'b1; need_down = 1'b0;
        write_word((m << 13) | (a << 11) | 250);
        check("R8 base after write", int'(act_half), b);
        for (int k = 1; k <= 5; k++) begin
          @(negedge clk);
          cur = (b + k > c) ? c : b + k;
          check("R7 climb", int'(act_half), cur);
          check("R6 core during climb", int'(core_khz), (exp_xk(250) * cur) / 2);
        end
        need_up = 1'b0; need_down = 1'b1;
        for (int k = 1; k <= 5; k++) begin
          @(negedge clk);
          cur = (c - k < b) ? b : c - k;
          check("R7 descent", int'(act_half), cur);
        end
        need_down = 1'b0;
      end

    // Worked example word 0x9BE8: 12 MHz crystal, 42 MHz base, 66 MHz ceiling
    auto_en = 1'b1; need_up = 1'b0;
    write_word(16'h9BE8);
    check("R4 example xtal", int'(xtal_khz), 12000);
    check("R6 example base clock", int'(core_khz), 42000);
    need_up = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 example ceiling clock", int'(core_khz), 66000);

    // Tie between up and down (R9)
    need_up = 1'b0;
    write_word((0 << 13) | (3 << 11));
    need_up = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 pre-tie level", int'(act_half), 4);
    need_down = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 tie holds", int'(act_half), 4);
    end
    need_down = 1'b0;
    @(negedge clk);
    check("R7 resume after tie", int'(act_half), 5);

    // Disable returns to base (R8), and stays there while demand persists
    auto_en = 1'b0;
    @(negedge clk);
    check("R8 disable to base", int'(act_half), 2);
    @(negedge clk);
    check("R8 no step while disabled", int'(act_half), 2);

    // Write while raised returns to new base (R8)
    auto_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 raised before write", int'(act_half), 5);
    need_up = 1'b0;
    write_word((2 << 13) | (2 << 11));
    check("R8 write to new base", int'(act_half), 5);
    check("R3 new ceiling", int'(ceil_half), 8);

    // Settle spacing (R10)
    for (int si = 1; si <= 3; si++) begin
      s = si * 2 - 1;
      settle_cycles = 8'(s);
      need_up = 1'b1;
      write_word((0 << 13) | (3 << 11));
      for (int k = 1; k <= 5 * (s + 1); k++) begin
        @(negedge clk);
        cur = 2 + k / (s + 1);
        if (cur > 6) cur = 6;
        check("R10 settle spacing", int'(act_half), cur);
      end
      need_up = 1'b0;
    end

    xk = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad + xk);
    $finish;
  end
endmodule